// File: doc/BRIEF.md
# RGB to YCbCr Colour Converter

This block converts a stream of full-range 8-bit RGB pixels into limited-range YCbCr 4:4:4 (BT.601 or BT.709 weights) or into limited-range RGB. It does this with a programmable 3x3 matrix followed by a per-row integer offset. Each of the three output rows forms a weighted sum of the green, red and blue inputs, adds its own offset, rounds and clamps. The matrix decides which standard is produced, so switching standards means rewriting twelve coefficient words.

Software loads the twelve 16-bit sign-magnitude words one byte at a time through a small write port. The same port carries a control byte. One control bit turns the conversion on or off; when it is off, pixels pass through untouched. Another control bit decides whether the first and third output components are exchanged. Pixels arrive with a valid qualifier and horizontal sync, vertical sync and data-enable sidebands. Data and sidebands leave together after a fixed pipeline delay.

Top module: `rgb_ycc_csc`

## Requirements
- R1: After reset, every output is 0, the converter is off and the component exchange is off (control reads as 0b10), so pixels pass straight through in input order.
- R2: A write to byte address A (0..23) stores one coefficient byte. Word w = A/2 is big-endian, with the even address holding the high byte. Word w feeds output row w/4 as term w%4: 0 = green weight, 1 = red weight, 2 = blue weight, 3 = offset. Address 24 is the control byte: bit 0 = converter on, bit 1 = exchange off.
- R3: In each word, bit 12 is the sign (1 = negative) and bits 11:0 are the magnitude. Bits 15:13 have no effect. Weights carry 10 fraction bits (0x400 = 1.0); offsets are plain integers.
- R4: With the converter on, row k gives clamp(floor((Gw*G + Rw*R + Bw*B + off*1024 + 512) / 1024)). That is, it rounds to nearest with halves rounded up.
- R5: Loaded with BT.601 weights (Cr row 0, Y row 1, Cb row 2; chroma offsets 128, luma offset 16), black maps to (128,16,128) and white maps to (128,235,128).
- R6: BT.709 weights give results that match the formula of R4 for every tested pixel, extremes included.
- R7: In limited-range RGB mode (diagonal weight 0x36F on R for row 0, G for row 1, B for row 2; offsets 16), an input of 0 gives 16 and an input of 255 gives 235.
- R8: With the converter off, output 0/1/2 equal the input R/G/B unchanged.
- R9: With control bit 1 at 0, outputs 0 and 2 are exchanged, whether the converter is on or off. With the bit at 1, no exchange happens.
- R10: Data, valid, hsync, vsync and DE all appear exactly 3 clocks after they are sampled.
- R11: Results below 0 give 0 and results above 255 give 255.
- R12: A configuration write applies to pixels sampled on later clock edges, not to the pixel sampled on the same edge. Writes to addresses 25..31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 5 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte data |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_hs_i | input | 1 | Input horizontal sync |
| pix_vs_i | input | 1 | Input vertical sync |
| pix_de_i | input | 1 | Input data enable |
| pix_g_i | input | 8 | Input green |
| pix_r_i | input | 8 | Input red |
| pix_b_i | input | 8 | Input blue |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_hs_o | output | 1 | Output horizontal sync |
| pix_vs_o | output | 1 | Output vertical sync |
| pix_de_o | output | 1 | Output data enable |
| pix_c0_o | output | 8 | Output component 0 (row 0, or row 2 when exchanged) |
| pix_c1_o | output | 8 | Output component 1 (row 1) |
| pix_c2_o | output | 8 | Output component 2 (row 2, or row 0 when exchanged) |

## Verification
The bench uses the default parameters: 8-bit channels, 10 fraction bits, the sign at bit 12 and a 5-bit address. With 8-bit channels, the all-0 and all-255 corner pixels can be driven directly alongside random traffic. A 12-bit magnitude reaches almost 4.0, so a single weight can push a row past 255, and a negative weight or offset can pull it below zero; both clamp edges are therefore reachable. The 5-bit address leaves seven addresses above the control byte, so writes that must be ignored can be mixed into live traffic. The bench also rewrites the configuration while pixels are streaming.

// File: rtl/csc_pkg.sv
package csc_pkg;
  // Three weighted inputs plus one offset per output row.
  localparam int CSC_ROWS       = 3;
  localparam int CSC_INPUTS     = 3;
  localparam int CSC_TERMS      = CSC_INPUTS + 1;
  localparam int CSC_WORD_BYTES = 2;
  localparam int CSC_LATENCY    = 3;

  typedef struct packed {
    logic vld;
    logic hs;
    logic vs;
    logic de;
  } csc_side_t;

  localparam int CSC_SIDE_W = $bits(csc_side_t);
endpackage

// File: rtl/csc_delay_line.sv
module csc_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [DEPTH-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < DEPTH; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs import csc_pkg::*; #(
  parameter int SIGN_POS = 12,
  parameter int ADDR_W   = 5
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     we_i,
  input  logic [ADDR_W-1:0]                        addr_i,
  input  logic [7:0]                               wdata_i,
  output logic [CSC_ROWS*CSC_TERMS*(SIGN_POS+1)-1:0] words_o,
  output logic                                     conv_en_o,
  output logic                                     swap_off_o
);
  localparam int SM_W      = SIGN_POS + 1;
  localparam int NUM_WORDS = CSC_ROWS * CSC_TERMS;
  localparam int NUM_BYTES = NUM_WORDS * CSC_WORD_BYTES;
  localparam int CTRL_ADDR = NUM_BYTES;

  // Only the sign and magnitude bits are kept; upper word bits are dropped.
  logic [NUM_WORDS-1:0][SM_W-1:0] word_q;
  logic [ADDR_W-2:0]              word_idx;
  logic                           byte_low;
  logic                           coef_hit;
  logic                           ctrl_hit;

  assign word_idx = addr_i[ADDR_W-1:1];
  assign byte_low = addr_i[0];
  assign coef_hit = we_i && (int'(addr_i) < NUM_BYTES);
  assign ctrl_hit = we_i && (int'(addr_i) == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (coef_hit) begin
      if (byte_low) word_q[word_idx][7:0]      <= wdata_i;
      else          word_q[word_idx][SM_W-1:8] <= wdata_i[SM_W-9:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_en_o  <= 1'b0;
      swap_off_o <= 1'b1;
    end else if (ctrl_hit) begin
      conv_en_o  <= wdata_i[0];
      swap_off_o <= wdata_i[1];
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words_o[w*SM_W +: SM_W] = word_q[w];
  end
endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac import csc_pkg::*; #(
  parameter int DATA_W    = 8,
  parameter int FRAC_BITS = 10,
  parameter int SIGN_POS  = 12
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [CSC_INPUTS*DATA_W-1:0]       pix_i,
  input  logic [CSC_TERMS*(SIGN_POS+1)-1:0]  row_coef_i,
  output logic [DATA_W-1:0]                  res_o
);
  localparam int SM_W  = SIGN_POS + 1;
  localparam int MAG_W = SIGN_POS;
  localparam int WIDE  = (FRAC_BITS > DATA_W) ? FRAC_BITS : DATA_W;
  localparam int ACC_W = MAG_W + WIDE + 4;
  localparam logic signed [ACC_W-1:0] ROUND_HALF = ACC_W'(1) <<< (FRAC_BITS - 1);
  localparam logic signed [ACC_W-1:0] PIX_MAX    = ACC_W'((1 << DATA_W) - 1);

  logic signed [ACC_W-1:0] term_d [CSC_TERMS];
  logic signed [ACC_W-1:0] term_q [CSC_TERMS];
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] whole;

  for (genvar k = 0; k < CSC_TERMS; k++) begin : g_term
    logic [MAG_W-1:0] mag;
    logic             neg;
    logic [ACC_W-1:0] mag_scaled;

    assign mag = row_coef_i[k*SM_W +: MAG_W];
    assign neg = row_coef_i[k*SM_W + SIGN_POS];

    if (k < CSC_INPUTS) begin : g_weight
      assign mag_scaled = ACC_W'(mag) * ACC_W'(pix_i[k*DATA_W +: DATA_W]);
    end else begin : g_offset
      assign mag_scaled = ACC_W'(mag) << FRAC_BITS;
    end

    assign term_d[k] = neg ? -$signed(mag_scaled) : $signed(mag_scaled);
  end

  // Stage 1: signed products and offset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < CSC_TERMS; k++) term_q[k] <= '0;
    end else begin
      for (int k = 0; k < CSC_TERMS; k++) term_q[k] <= term_d[k];
    end
  end

  // Stage 2: sum with rounding bias.
  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= term_q[0] + term_q[1] + term_q[2] + term_q[3] + ROUND_HALF;
  end

  assign whole = acc_q >>> FRAC_BITS;

  always_comb begin
    if (whole < 0)            res_o = '0;
    else if (whole > PIX_MAX) res_o = '1;
    else                      res_o = whole[DATA_W-1:0];
  end
endmodule

// File: rtl/rgb_ycc_csc.sv
module rgb_ycc_csc import csc_pkg::*; #(
  parameter int DATA_W     = 8,
  parameter int FRAC_BITS  = 10,
  parameter int SIGN_POS   = 12,
  parameter int CFG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [7:0]            cfg_wdata,
  input  logic                  pix_vld_i,
  input  logic                  pix_hs_i,
  input  logic                  pix_vs_i,
  input  logic                  pix_de_i,
  input  logic [DATA_W-1:0]     pix_g_i,
  input  logic [DATA_W-1:0]     pix_r_i,
  input  logic [DATA_W-1:0]     pix_b_i,
  output logic                  pix_vld_o,
  output logic                  pix_hs_o,
  output logic                  pix_vs_o,
  output logic                  pix_de_o,
  output logic [DATA_W-1:0]     pix_c0_o,
  output logic [DATA_W-1:0]     pix_c1_o,
  output logic [DATA_W-1:0]     pix_c2_o
);
  localparam int SM_W          = SIGN_POS + 1;
  localparam int ROW_COEF_W    = CSC_TERMS * SM_W;
  localparam int PIX_W         = CSC_INPUTS * DATA_W;
  localparam int BYP_W         = PIX_W + 2;
  localparam int CFG_CTRL_ADDR = CSC_ROWS * CSC_TERMS * CSC_WORD_BYTES;

  logic [CSC_ROWS*ROW_COEF_W-1:0]       coef_all;
  logic                                 ctrl_en;
  logic                                 ctrl_swap_off;
  logic [PIX_W-1:0]                     pix_in;
  logic [CSC_ROWS-1:0][DATA_W-1:0]      row_res;
  logic [BYP_W-1:0]                     byp_d;
  logic [BYP_W-1:0]                     byp_q;
  csc_side_t                            side_d;
  csc_side_t                            side_q;

  csc_cfg_regs #(
    .SIGN_POS (SIGN_POS),
    .ADDR_W   (CFG_ADDR_W)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we_i       (cfg_we),
    .addr_i     (cfg_addr),
    .wdata_i    (cfg_wdata),
    .words_o    (coef_all),
    .conv_en_o  (ctrl_en),
    .swap_off_o (ctrl_swap_off)
  );

  // Term order inside a row: green, red, blue.
  assign pix_in = {pix_b_i, pix_r_i, pix_g_i};

  for (genvar r = 0; r < CSC_ROWS; r++) begin : g_row
    csc_row_mac #(
      .DATA_W    (DATA_W),
      .FRAC_BITS (FRAC_BITS),
      .SIGN_POS  (SIGN_POS)
    ) u_mac (
      .clk        (clk),
      .rst        (rst),
      .pix_i      (pix_in),
      .row_coef_i (coef_all[r*ROW_COEF_W +: ROW_COEF_W]),
      .res_o      (row_res[r])
    );
  end

  // Control and raw pixel travel beside the matrix for the output stage.
  assign byp_d = {ctrl_en, ctrl_swap_off, pix_r_i, pix_g_i, pix_b_i};

  csc_delay_line #(
    .WIDTH (BYP_W),
    .DEPTH (CSC_LATENCY - 1)
  ) u_byp_dly (
    .clk (clk),
    .rst (rst),
    .d_i (byp_d),
    .q_o (byp_q)
  );

  assign side_d = '{vld: pix_vld_i, hs: pix_hs_i, vs: pix_vs_i, de: pix_de_i};

  csc_delay_line #(
    .WIDTH (CSC_SIDE_W),
    .DEPTH (CSC_LATENCY)
  ) u_side_dly (
    .clk (clk),
    .rst (rst),
    .d_i (side_d),
    .q_o (side_q)
  );

  assign pix_vld_o = side_q.vld;
  assign pix_hs_o  = side_q.hs;
  assign pix_vs_o  = side_q.vs;
  assign pix_de_o  = side_q.de;

  // Stage 3: select, optional exchange, register.
  logic              en_d;
  logic              swap_off_d;
  logic [DATA_W-1:0] raw_r;
  logic [DATA_W-1:0] raw_g;
  logic [DATA_W-1:0] raw_b;
  logic [DATA_W-1:0] sel0;
  logic [DATA_W-1:0] sel1;
  logic [DATA_W-1:0] sel2;
  logic [DATA_W-1:0] fin0;
  logic [DATA_W-1:0] fin2;

  assign {en_d, swap_off_d, raw_r, raw_g, raw_b} = byp_q;

  always_comb begin
    if (en_d) begin
      sel0 = row_res[0];
      sel1 = row_res[1];
      sel2 = row_res[2];
    end else begin
      sel0 = raw_r;
      sel1 = raw_g;
      sel2 = raw_b;
    end
    fin0 = swap_off_d ? sel0 : sel2;
    fin2 = swap_off_d ? sel2 : sel0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_c0_o <= '0;
      pix_c1_o <= '0;
      pix_c2_o <= '0;
    end else begin
      pix_c0_o <= fin0;
      pix_c1_o <= sel1;
      pix_c2_o <= fin2;
    end
  end
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [1:0]        cfg_ctrl_bits,
  input logic              conv_en,
  input logic              swap_off,
  input logic              vld_i,
  input logic              hs_i,
  input logic              vs_i,
  input logic              de_i,
  input logic [DATA_W-1:0] g_i,
  input logic [DATA_W-1:0] r_i,
  input logic [DATA_W-1:0] b_i,
  input logic              vld_o,
  input logic              hs_o,
  input logic              vs_o,
  input logic              de_o,
  input logic [DATA_W-1:0] c0,
  input logic [DATA_W-1:0] c1,
  input logic [DATA_W-1:0] c2
);
  logic [1:0] warm;
  logic       rst_seen;

  always_ff @(posedge clk) begin
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      assert_reset_clear_R1: assert ({vld_o, hs_o, vs_o, de_o} == 4'b0 && c0 == '0 &&
                                      c1 == '0 && c2 == '0 && !conv_en && swap_off)
        else $error("outputs or control not cleared by reset");
    end
  end

  assert_side_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> ({vld_o, hs_o, vs_o, de_o} == $past({vld_i, hs_i, vs_i, de_i}, 3)));

  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && !$past(conv_en, 3) && $past(swap_off, 3)) |->
      (c0 == $past(r_i, 3) && c1 == $past(g_i, 3) && c2 == $past(b_i, 3)));

  assert_bypass_swap_R9: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && !$past(conv_en, 3) && !$past(swap_off, 3)) |->
      (c0 == $past(b_i, 3) && c1 == $past(g_i, 3) && c2 == $past(r_i, 3)));

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_addr) == CTRL_ADDR) |=>
      (conv_en == $past(cfg_ctrl_bits[0]) && swap_off == $past(cfg_ctrl_bits[1])));

  assert_ignored_addr_R12: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_addr) > CTRL_ADDR) |=> $stable({conv_en, swap_off}));
endmodule

bind rgb_ycc_csc csc_checker #(
  .DATA_W    (DATA_W),
  .ADDR_W    (CFG_ADDR_W),
  .CTRL_ADDR (CFG_CTRL_ADDR)
) u_csc_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_we        (cfg_we),
  .cfg_addr      (cfg_addr),
  .cfg_ctrl_bits (cfg_wdata[1:0]),
  .conv_en       (ctrl_en),
  .swap_off      (ctrl_swap_off),
  .vld_i         (pix_vld_i),
  .hs_i          (pix_hs_i),
  .vs_i          (pix_vs_i),
  .de_i          (pix_de_i),
  .g_i           (pix_g_i),
  .r_i           (pix_r_i),
  .b_i           (pix_b_i),
  .vld_o         (pix_vld_o),
  .hs_o          (pix_hs_o),
  .vs_o          (pix_vs_o),
  .de_o          (pix_de_o),
  .c0            (pix_c0_o),
  .c1            (pix_c1_o),
  .c2            (pix_c2_o)
);

// File: tb/rgb_ycc_csc_tb_top.sv
module rgb_ycc_csc_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [4:0]    cfg_addr;
  logic [7:0]    cfg_wdata;
  logic          vld, hs, vs, de;
  logic [DW-1:0] pg, pr, pb;
  logic          vld_o, hs_o, vs_o, de_o;
  logic [DW-1:0] c0, c1, c2;

  always #5 clk = ~clk;

  rgb_ycc_csc dut_i (
    .clk (clk), .rst (rst),
    .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
    .pix_vld_i (vld), .pix_hs_i (hs), .pix_vs_i (vs), .pix_de_i (de),
    .pix_g_i (pg), .pix_r_i (pr), .pix_b_i (pb),
    .pix_vld_o (vld_o), .pix_hs_o (hs_o), .pix_vs_o (vs_o), .pix_de_o (de_o),
    .pix_c0_o (c0), .pix_c1_o (c1), .pix_c2_o (c2)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";

  // Behavioural reference: configuration image, control and a result queue.
  logic [7:0]  mdl_mem [24];
  logic        m_en;
  logic        m_soff;
  logic [27:0] expq [$];

  function automatic int coef_val(int row, int k);
    logic [15:0] w;
    w = {mdl_mem[8*row + 2*k], mdl_mem[8*row + 2*k + 1]};
    return w[12] ? -int'(w[11:0]) : int'(w[11:0]);
  endfunction

  function automatic int row_val(int row, int g, int r, int b);
    int acc;
    acc = coef_val(row, 0) * g + coef_val(row, 1) * r + coef_val(row, 2) * b
        + coef_val(row, 3) * 1024 + 512;
    acc = acc >>> 10;
    if (acc < 0)   acc = 0;
    if (acc > 255) acc = 255;
    return acc;
  endfunction

  always @(posedge clk) begin : model
    if (rst) begin
      expq.delete();
      foreach (mdl_mem[i]) mdl_mem[i] = 8'h00;
      m_en   = 1'b0;
      m_soff = 1'b1;
    end else begin
      int a0, a1, a2, t;
      if (m_en) begin
        a0 = row_val(0, pg, pr, pb);
        a1 = row_val(1, pg, pr, pb);
        a2 = row_val(2, pg, pr, pb);
      end else begin
        a0 = pr; a1 = pg; a2 = pb;
      end
      if (!m_soff) begin t = a0; a0 = a2; a2 = t; end
      expq.push_back({vld, hs, vs, de, a0[7:0], a1[7:0], a2[7:0]});
      if (cfg_we) begin
        if (cfg_addr < 5'd24) mdl_mem[cfg_addr] = cfg_wdata;
        else if (cfg_addr == 5'd24) begin
          m_en   = cfg_wdata[0];
          m_soff = cfg_wdata[1];
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    if (!rst && expq.size() == 3) begin
      logic [27:0] e;
      e = expq.pop_front();
      checks += 2;
      if ({vld_o, hs_o, vs_o, de_o} !== e[27:24]) begin
        fails++;
        $display("FAIL R10 sideband: actual %b expected %b", {vld_o, hs_o, vs_o, de_o}, e[27:24]);
      end
      if ({c0, c1, c2} !== e[23:0]) begin
        fails++;
        $display("FAIL %s data: actual %h expected %h", tag, {c0, c1, c2}, e[23:0]);
      end
    end
  end

  task automatic cfg_wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[4:0]; cfg_wdata = d[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] sm(input int v, input bit junk);
    logic [15:0] w;
    w = (v < 0) ? (16'h1000 | 16'((-v) & 12'hFFF)) : 16'(v & 12'hFFF);
    if (junk) w = w | 16'hE000;
    return w;
  endfunction

  task automatic load_row(input int row, input int gw, input int rw, input int bw,
                          input int off, input bit junk);
    int vals[4];
    vals[0] = gw; vals[1] = rw; vals[2] = bw; vals[3] = off;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w;
      w = sm(vals[k], junk);
      cfg_wr(8*row + 2*k, w[15:8]);
      cfg_wr(8*row + 2*k + 1, w[7:0]);
    end
  endtask

  task automatic drive_px(input int r, input int g, input int b);
    @(negedge clk);
    pr = r[7:0]; pg = g[7:0]; pb = b[7:0];
    vld = 1'b1; de = 1'b1; hs = 1'b0; vs = 1'b0;
  endtask

  task automatic corners();
    for (int i = 0; i < 8; i++) begin
      drive_px(i[0] ? 255 : 0, i[1] ? 255 : 0, i[2] ? 255 : 0);
    end
    drive_px(128, 128, 128);
    drive_px(1, 1, 1);
  endtask

  task automatic stream(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pr = 8'($urandom); pg = 8'($urandom); pb = 8'($urandom);
      vld = 1'($urandom); hs = 1'($urandom); vs = 1'($urandom); de = 1'($urandom);
    end
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    vld = 0; hs = 0; vs = 0; de = 0; pg = 0; pr = 0; pb = 0;
    repeat (4) @(negedge clk);
    pr = 8'hAA; pg = 8'h55; pb = 8'h3C; vld = 1; hs = 1; vs = 1; de = 1;
    @(negedge clk);
    checks++;
    if ({vld_o, hs_o, vs_o, de_o, c0, c1, c2} !== 28'h0) begin
      fails++;
      $display("FAIL R1 reset state: actual %h expected 0", {vld_o, hs_o, vs_o, de_o, c0, c1, c2});
    end
    rst = 1'b0;

    tag = "R1 R8 default pass-through";
    stream(30);

    // BT.601 weights, rows Cr, Y, Cb
    load_row(0, -377, 450, -73, 128, 1'b0);
    load_row(1, 516, 263, 100, 16, 1'b0);
    load_row(2, -298, -152, 450, 128, 1'b0);
    cfg_wr(24, 3);
    tag = "R5 R2 R4 BT.601";
    corners();
    stream(150);

    tag = "R9 exchanged conversion";
    cfg_wr(24, 1);
    corners();
    stream(60);
    tag = "R8 R9 exchanged pass-through";
    cfg_wr(24, 0);
    stream(40);

    // BT.709 weights
    load_row(0, -409, 450, -41, 128, 1'b0);
    load_row(1, 629, 187, 63, 16, 1'b0);
    load_row(2, -346, -103, 450, 128, 1'b0);
    cfg_wr(24, 3);
    tag = "R6 R4 BT.709";
    corners();
    stream(150);

    // Limited-range RGB
    load_row(0, 0, 879, 0, 16, 1'b0);
    load_row(1, 879, 0, 0, 16, 1'b0);
    load_row(2, 0, 0, 879, 16, 1'b0);
    tag = "R7 limited RGB";
    corners();
    stream(80);

    // Saturating rows with junk in the unused word bits
    load_row(0, 4095, 0, 0, 0, 1'b1);
    load_row(1, 0, -1024, 512, 20, 1'b1);
    load_row(2, 0, 0, 0, -5, 1'b1);
    tag = "R11 R3 clamp and field decode";
    corners();
    stream(80);

    // Live writes, including unused addresses
    tag = "R12 R2 live writes";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pr = 8'($urandom); pg = 8'($urandom); pb = 8'($urandom);
      vld = 1'($urandom); hs = 1'($urandom); vs = 1'($urandom); de = 1'($urandom);
      if (i % 4 == 0) begin
        cfg_we = 1'b1;
        cfg_addr = (i % 12 == 0) ? 5'(25 + ($urandom % 7)) : 5'($urandom % 25);
        cfg_wdata = 8'($urandom);
      end else begin
        cfg_we = 1'b0;
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
    tag = "R10 R12 drain";
    stream(20);
    vld = 0; hs = 0; vs = 0; de = 0;
    repeat (6) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule